// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register Bank

This block is the software-visible register bank for a DMA unit with two channels. Channel 0 moves data from memory to a stream, and channel 1 moves data from a stream to memory. Each channel has a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer and a few general storage words. A single-cycle 32-bit access port finds the channel and the word from the byte address. Write data is taken at the clock edge. Read data is combinational from the current state and the address.

The block does not walk descriptors. A separate descriptor engine does that. The bank sends that engine a one-cycle tail-write pulse per channel, plus a start pulse when the transmit tail is written. It takes back halt, idle and interrupt-set events. The engine's live completion counter and delay-timer count arrive as inputs, and they are merged into status reads. Each channel drives a level interrupt made from its pending flags and their enables.

Top module: `dma_chan_csr`

## Requirements
- R1: The channel index is (addr / 48) mod 2 and the word index is (addr mod 48) >> 2. Addresses at 0x60 and above therefore alias back onto channel 0 and channel 1.
- R2: After reset, control reads 0x0001_0000 and status low half reads 0x0001 (halted). Every other word reads 0. irq_o, tail_wr_o and start_o are low.
- R3: On a control write (word 0) the stored value is the written value with bit 1 forced to 1. A read returns that value.
- R4: A control write with bit 2 set, or any control write while bit 2 is still pending, does three things. It reloads control to 0x0001_0000 with bits 1 and 2 set. It sets the status low half to 0x0001. It ignores the run bit. The next read of control returns the word with bit 2 cleared, and clears the pending bit.
- R5: A control write with bit 0 = 1, when neither that write nor a pending reset has bit 2 set, clears status bits 0 (halted) and 1 (idle).
- R6: A status write (word 1) clears each of status bits 14:12 that is written as 1 and leaves the others alone. The other status bits 15:0 take the written value.
- R7: irq_o[c] is the OR of status[14:12] AND control[14:12] of channel c. It follows a state change from the next cycle on.
- R8: A status read returns {delay count[7:0], completion count[7:0], stored status[15:0]}. The two counts are the channel's live inputs.
- R9: A write to the tail pointer (word 4) does the following:
  - it stores the value;
  - it clears the idle bit;
  - it pulses tail_wr_o[c] for the next cycle;
  - on channel 0 only, it also pulses start_o for the next cycle.
- R10: The engine's halt, idle and interrupt events set status bits 0, 1 and 14:12 respectively. A set wins over a clear made by software in the same cycle.
- R11: The current pointer (word 2) and the unmapped words 3 and 5 to 11 store and return all 32 bits, with no other effect.
- R12: A read changes nothing except the pending reset bit of control. An access to one channel leaves the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data for the current address |
| eng_halt_i | input | NUM_CH | Engine halt event per channel |
| eng_idle_i | input | NUM_CH | Engine idle event per channel |
| eng_irq_i | input | 3*NUM_CH | Engine interrupt-set events, 3 bits per channel |
| coal_cnt_i | input | 8*NUM_CH | Live completion counter per channel |
| dly_cnt_i | input | 8*NUM_CH | Live delay-timer count per channel |
| irq_o | output | NUM_CH | Interrupt line per channel |
| tail_wr_o | output | NUM_CH | Tail-written pulse per channel |
| start_o | output | 1 | Transmit start pulse |

## Verification
The sharpest case is an engine interrupt event that arrives in the same cycle as a software write-one-to-clear of that same status bit. The bench drives both on one clock edge. It then checks two things: the bit reads back as set, and the interrupt line stays high. A second same-cycle case is checked the same way. An engine idle event lands together with a tail write, and the idle bit must stay set. An address sweep runs across the whole address range, including the aliased windows. A bench-side model, built from the requirements, judges every readback and every pulse.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned STAT_LO_W = 16;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned IRQ_W     = 3;
  localparam int unsigned IRQ_LSB   = 12;

  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_TAIL  = 4;

  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_TPM  = 1;
  localparam int unsigned C_SRST = 2;
  localparam int unsigned S_HALT = 0;
  localparam int unsigned S_IDLE = 1;

  localparam logic [WORD_W-1:0]    CTRL_POR = 32'h0001_0000;
  localparam logic [STAT_LO_W-1:0] STAT_POR = 16'h0001;

  typedef struct packed {
    logic             halt;
    logic             idle;
    logic [IRQ_W-1:0] irq;
  } eng_evt_t;
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WIN_BYTES = 48,
  parameter int unsigned NUM_CH    = 2,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned REG_W    = $clog2(WIN_BYTES / 4)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [REG_W-1:0]  reg_o
);
  // window stride is not a power of two: true divide/modulo by constant
  assign ch_o  = CH_W'(addr_i / ADDR_W'(WIN_BYTES));
  assign reg_o = REG_W'((addr_i % ADDR_W'(WIN_BYTES)) >> 2);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned REG_W    = 4,
  parameter bit          TX_CHAN  = 1'b0,
  localparam int unsigned DEPTH   = 1 << REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  eng_evt_t          evt_i,
  input  logic [CNT_W-1:0]  coal_i,
  input  logic [CNT_W-1:0]  dly_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tail_wr_o,
  output logic              start_o
);
  localparam logic [WORD_W-1:0] M_TPM  = WORD_W'(1) << C_TPM;
  localparam logic [WORD_W-1:0] M_SRST = WORD_W'(1) << C_SRST;

  logic [WORD_W-1:0]    ctrl_q, ctrl_d, wv;
  logic [STAT_LO_W-1:0] stat_q, stat_d;
  logic [WORD_W-1:0]    word_q [DEPTH];
  logic                 sel_ctrl, sel_stat, sel_tail;
  logic                 tail_q, start_q;

  assign sel_ctrl = (reg_i == REG_W'(IDX_CTRL));
  assign sel_stat = (reg_i == REG_W'(IDX_STAT));
  assign sel_tail = (reg_i == REG_W'(IDX_TAIL));

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    wv     = '0;
    if (rd_i && sel_ctrl) ctrl_d[C_SRST] = 1'b0;
    if (wr_i) begin
      if (sel_ctrl) begin
        wv = wdata_i | M_TPM | (ctrl_q & M_SRST);
        if (wv[C_SRST]) begin
          ctrl_d = CTRL_POR | M_TPM | M_SRST;
          stat_d = STAT_POR;
        end else begin
          ctrl_d = wv;
          if (wv[C_RUN]) begin
            stat_d[S_HALT] = 1'b0;
            stat_d[S_IDLE] = 1'b0;
          end
        end
      end else if (sel_stat) begin
        stat_d = wdata_i[STAT_LO_W-1:0];
        stat_d[IRQ_LSB +: IRQ_W] = stat_q[IRQ_LSB +: IRQ_W] & ~wdata_i[IRQ_LSB +: IRQ_W];
      end else if (sel_tail) begin
        stat_d[S_IDLE] = 1'b0;
      end
    end
    // engine sets win over same-cycle software clears
    stat_d[S_HALT] = stat_d[S_HALT] | evt_i.halt;
    stat_d[S_IDLE] = stat_d[S_IDLE] | evt_i.idle;
    stat_d[IRQ_LSB +: IRQ_W] = stat_d[IRQ_LSB +: IRQ_W] | evt_i.irq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_POR;
      stat_q  <= STAT_POR;
      tail_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      tail_q  <= wr_i && sel_tail;
      start_q <= TX_CHAN && wr_i && sel_tail;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    if (i == IDX_CTRL || i == IDX_STAT || i >= NUM_REGS) begin : g_none
      assign word_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                word_q[i] <= '0;
        else if (wr_i && reg_i == REG_W'(i))        word_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    if (sel_ctrl)      rdata_o = ctrl_q & ~M_SRST;
    else if (sel_stat) rdata_o = {dly_i, coal_i, stat_q};
    else               rdata_o = word_q[reg_i];
  end

  assign irq_o     = |(stat_q[IRQ_LSB +: IRQ_W] & ctrl_q[IRQ_LSB +: IRQ_W]);
  assign tail_wr_o = tail_q;
  assign start_o   = start_q;
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WIN_BYTES = 48,
  parameter int unsigned NUM_CH    = 2,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned NUM_REGS = WIN_BYTES / 4,
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [WORD_W-1:0]       req_wdata_i,
  output logic [WORD_W-1:0]       rsp_rdata_o,
  input  logic [NUM_CH-1:0]       eng_halt_i,
  input  logic [NUM_CH-1:0]       eng_idle_i,
  input  logic [NUM_CH*IRQ_W-1:0] eng_irq_i,
  input  logic [NUM_CH*CNT_W-1:0] coal_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] dly_cnt_i,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [NUM_CH-1:0]       tail_wr_o,
  output logic                    start_o
);
  logic [CH_W-1:0]   ch_sel;
  logic [REG_W-1:0]  reg_sel;
  logic [WORD_W-1:0] rd_v [NUM_CH];
  logic [NUM_CH-1:0] start_v;

  dma_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NUM_CH(NUM_CH)
  ) u_dec (
    .addr_i(req_addr_i), .ch_o(ch_sel), .reg_o(reg_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    eng_evt_t evt;
    logic     hit;
    assign hit = req_valid_i && (ch_sel == CH_W'(c));
    assign evt = '{halt: eng_halt_i[c], idle: eng_idle_i[c],
                   irq: eng_irq_i[c*IRQ_W +: IRQ_W]};

    dma_chan_regs #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .TX_CHAN(c == 0)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (hit && req_write_i),
      .rd_i      (hit && !req_write_i),
      .reg_i     (reg_sel),
      .wdata_i   (req_wdata_i),
      .evt_i     (evt),
      .coal_i    (coal_cnt_i[c*CNT_W +: CNT_W]),
      .dly_i     (dly_cnt_i[c*CNT_W +: CNT_W]),
      .rdata_o   (rd_v[c]),
      .irq_o     (irq_o[c]),
      .tail_wr_o (tail_wr_o[c]),
      .start_o   (start_v[c])
    );
  end

  assign rsp_rdata_o = rd_v[ch_sel];
  assign start_o     = |start_v;
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WIN_BYTES = 48,
  parameter int unsigned NUM_CH    = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_write_i,
  input logic [ADDR_W-1:0]       req_addr_i,
  input logic [IRQ_W-1:0]        w_irq_i,
  input logic [WORD_W-1:16]      rd_hi_i,
  input logic                    rd_srst_i,
  input logic [NUM_CH*IRQ_W-1:0] eng_irq_i,
  input logic [NUM_CH*CNT_W-1:0] coal_cnt_i,
  input logic [NUM_CH*CNT_W-1:0] dly_cnt_i,
  input logic [NUM_CH-1:0]       irq_o,
  input logic [NUM_CH-1:0]       tail_wr_o,
  input logic                    start_o
);
  int a_ch, a_reg;
  logic is_wr, is_rd;
  always_comb begin
    a_ch  = (int'(req_addr_i) / int'(WIN_BYTES)) % int'(NUM_CH);
    a_reg = (int'(req_addr_i) % int'(WIN_BYTES)) / 4;
  end
  assign is_wr = req_valid_i && req_write_i;
  assign is_rd = req_valid_i && !req_write_i;

  // R9
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && a_ch == 0 && a_reg == int'(IDX_TAIL)) |=> start_o);
  // R9
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(is_wr && a_ch == 0 && a_reg == int'(IDX_TAIL)));
  // R4
  ctrl_rd_srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && a_reg == int'(IDX_CTRL)) |-> !rd_srst_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R6
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_wr && a_ch == c && a_reg == int'(IDX_STAT) && w_irq_i == '1 &&
       eng_irq_i[c*IRQ_W +: IRQ_W] == '0) |=> !irq_o[c]);
    // R7
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(eng_irq_i[c*IRQ_W +: IRQ_W] != '0 ||
                                (is_wr && a_ch == c && a_reg == int'(IDX_CTRL))));
    // R8
    stat_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_rd && a_ch == c && a_reg == int'(IDX_STAT)) |->
        rd_hi_i == {dly_cnt_i[c*CNT_W +: CNT_W], coal_cnt_i[c*CNT_W +: CNT_W]});
    // R9
    tail_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_wr_o[c] |-> $past(is_wr && a_ch == c && a_reg == int'(IDX_TAIL)));
  end
endmodule

bind dma_chan_csr dma_chan_csr_chk #(
  .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NUM_CH(NUM_CH)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .w_irq_i     (req_wdata_i[14:12]),
  .rd_hi_i     (rsp_rdata_o[31:16]),
  .rd_srst_i   (rsp_rdata_o[2]),
  .eng_irq_i   (eng_irq_i),
  .coal_cnt_i  (coal_cnt_i),
  .dly_cnt_i   (dly_cnt_i),
  .irq_o       (irq_o),
  .tail_wr_o   (tail_wr_o),
  .start_o     (start_o)
);

// File: tb/dma_chan_csr_tb_top.sv
`timescale 1ns/1ps
module dma_chan_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  e_halt = '0, e_idle = '0;
  logic [5:0]  e_irq = '0;
  logic [15:0] t_coal = '0, t_dly = '0;
  logic [1:0]  irq, tail_wr;
  logic        start;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [2];
  logic [15:0] m_stat [2];
  logic [31:0] m_word [2][12];

  always #2.5 clk = ~clk;

  dma_chan_csr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .eng_halt_i(e_halt), .eng_idle_i(e_idle), .eng_irq_i(e_irq),
    .coal_cnt_i(t_coal), .dly_cnt_i(t_dly), .irq_o(irq),
    .tail_wr_o(tail_wr), .start_o(start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int c, int r);
    if (r == 0)      return m_ctrl[c] & ~32'h4;
    else if (r == 1) return {t_dly[c*8 +: 8], t_coal[c*8 +: 8], m_stat[c]};
    else             return m_word[c][r];
  endfunction

  function automatic logic [1:0] exp_irq();
    logic [1:0] v;
    for (int c = 0; c < 2; c++) v[c] = |(m_stat[c][14:12] & m_ctrl[c][14:12]);
    return v;
  endfunction

  task automatic m_write(int c, int r, logic [31:0] d);
    logic [31:0] v;
    if (r == 0) begin
      v = d | 32'h2 | (m_ctrl[c] & 32'h4);
      if (v[2]) begin
        m_ctrl[c] = 32'h0001_0006;
        m_stat[c] = 16'h0001;
      end else begin
        m_ctrl[c] = v;
        if (v[0]) m_stat[c][1:0] = 2'b00;
      end
    end else if (r == 1) begin
      m_stat[c] = {d[15], m_stat[c][14:12] & ~d[14:12], d[11:0]};
    end else begin
      m_word[c][r] = d;
      if (r == 4) m_stat[c][1] = 1'b0;
    end
  endtask

  task automatic bus_op(input bit wr, input int a, input logic [31:0] d,
                        input logic [1:0] eh, input logic [1:0] ei,
                        input logic [5:0] eq, input string req);
    int c, r;
    logic [31:0] exp, act;
    c = (a / 48) % 2;
    r = (a % 48) / 4;
    exp = exp_rd(c, r);
    @(negedge clk);
    valid = 1'b1; write = wr; addr = 8'(a); wdata = d;
    e_halt = eh; e_idle = ei; e_irq = eq;
    #1 act = rdata;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; e_halt = '0; e_idle = '0; e_irq = '0;
    if (!wr) chk(req, act, exp);
    if (wr) m_write(c, r, d);
    else if (r == 0) m_ctrl[c][2] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (eh[k]) m_stat[k][0] = 1'b1;
      if (ei[k]) m_stat[k][1] = 1'b1;
      m_stat[k][14:12] = m_stat[k][14:12] | eq[k*3 +: 3];
    end
    chk({req, " tail"}, {30'd0, tail_wr}, (wr && r == 4) ? (32'd1 << c) : 32'd0);
    chk({req, " start"}, {31'd0, start}, {31'd0, wr && r == 4 && c == 0});
    chk({req, " R7 irq"}, {30'd0, irq}, {30'd0, exp_irq()});
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string req);
    bus_op(1'b1, a, d, 2'b00, 2'b00, 6'd0, req);
  endtask
  task automatic rd(input int a, input string req);
    bus_op(1'b0, a, 32'd0, 2'b00, 2'b00, 6'd0, req);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 32'h0001_0000;
      m_stat[c] = 16'h0001;
      for (int r = 0; r < 12; r++) m_word[c][r] = '0;
    end
    t_coal = 16'h2211; t_dly = 16'h4433;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: outputs and every word after reset
    chk("R2 irq", {30'd0, irq}, 32'd0);
    chk("R2 tail", {30'd0, tail_wr}, 32'd0);
    chk("R2 start", {31'd0, start}, 32'd0);
    for (int a = 0; a < 96; a += 4) rd(a, "R2 R8 reset read");

    // R3 R5: run and mask bits on channel 1
    wr(8'h30, 32'h0000_7001, "R3 ctrl wr");
    rd(8'h30, "R3 ctrl rd");
    rd(8'h34, "R5 halt clear");
    // R10 R7: engine event raises irq
    bus_op(1'b0, 8'h34, 0, 2'b00, 2'b00, 6'b001_000, "R10 evt");
    rd(8'h34, "R10 stat set");
    // R10: concurrent W1C and set, set wins
    bus_op(1'b1, 8'h34, 32'h0000_1000, 2'b00, 2'b00, 6'b001_000, "R10 w1c vs set");
    rd(8'h34, "R10 stays set");
    // R6: W1C alone clears
    wr(8'h34, 32'h0000_7000, "R6 w1c");
    rd(8'h34, "R6 cleared");
    // R7: masked flag does not drive irq
    wr(8'h30, 32'h0000_0001, "R7 unmask off");
    bus_op(1'b0, 8'h00, 0, 2'b00, 2'b00, 6'b010_000, "R7 masked evt");
    rd(8'h34, "R7 flag visible");
    wr(8'h30, 32'h0000_2001, "R7 enable");

    // R4: sticky reset on channel 0
    wr(8'h00, 32'h0000_7005, "R4 reset wr");
    rd(8'h04, "R4 halted");
    wr(8'h00, 32'h0000_0001, "R4 run while pending");
    rd(8'h04, "R4 still halted");
    rd(8'h00, "R4 ctrl rd clears");
    wr(8'h00, 32'h0000_0001, "R5 run");
    rd(8'h04, "R5 running");

    // R9: tail pulses, idle clear, concurrent idle set
    bus_op(1'b0, 8'h00, 0, 2'b00, 2'b11, 6'd0, "R10 idle evt");
    wr(8'h10, 32'hCAFE_0010, "R9 tx tail");
    rd(8'h04, "R9 idle cleared");
    wr(8'h40, 32'hBEEF_0040, "R9 rx tail");
    bus_op(1'b1, 8'h40, 32'h1234_5678, 2'b00, 2'b10, 6'd0, "R10 idle vs tail");
    rd(8'h34, "R10 idle kept");
    bus_op(1'b0, 8'h04, 0, 2'b01, 2'b00, 6'd0, "R10 halt evt");
    rd(8'h04, "R10 halt set");

    // R1 R11 R12: sweep the whole address range, aliased windows included
    for (int a = 0; a < 256; a += 4) begin
      logic [7:0] ab;
      ab = 8'(a);
      t_coal = {~ab, ab}; t_dly = {ab ^ 8'h5A, ab + 8'd3};
      wr(a, {~ab, ab ^ 8'h3C, ab, 8'h96 ^ {ab[3:0], 4'h0}}, "R1 R11 sweep wr");
      rd(a, "R1 R11 sweep rd");
    end
    for (int a = 0; a < 96; a += 4) rd(a, "R12 final");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule